// File: doc/BRIEF.md
# Dispatch Unit with Reservation Station

This block sits between the rename stage and the execution stage. Micro-ops arrive one per cycle and are first written into a small in-order input queue. Each cycle the micro-op at the head of that queue is examined. If it has no unresolved source dependency, and its target execution unit still has a free issue-queue slot, it goes straight to the dispatch outputs. If it cannot go out at once, it is parked in the reservation station (instruction window). If the window has no free slot, the micro-op stays at the head of the queue.

Window entries wait until a wakeup broadcast names the micro-op they depend on. Up to `LANES` micro-ops leave per cycle, oldest program-order ID first. The execution stage reports a per-unit credit, which is the number of free slots in that unit's issue queue. No unit ever receives more micro-ops in a cycle than its credit allows. A flush, raised for example on a mispredicted conditional branch, throws away everything held in the queue and in the window.

Each micro-op carries a program-order ID, a unit selector, a dependency flag with a producer ID, and an opaque payload word. The payload stands for the address, opcode and operand fields, and is carried through unchanged.

Top module: `dispatch_rs`

## Requirements
- R1: After reset the queue and window are empty, so `out_valid` is all zero and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the input queue holds fewer than `QDEPTH` micro-ops. A micro-op is written into the queue when `in_valid && in_ready && !flush`. Micro-ops leave the queue only in arrival order.
- R3: In the same cycle, the queue head appears on the dispatch outputs with its ID, unit and payload unchanged if all of the following hold: its dependency is clear, an output lane is still free after the window's picks, and its unit still has credit.
- R4: A queue head that cannot be dispatched moves into the window when a window slot is free. When the window is full it stays in the queue, so the queue fills up and `in_ready` drops.
- R5: A wakeup (`wk_valid` with `wk_id`) clears every pending dependency whose producer ID equals `wk_id`. This applies to window entries, to queue entries, and to a micro-op accepted in the same cycle. The cleared micro-op can be dispatched from the following cycle.
- R6: Ready window entries are dispatched oldest first, by ascending ID, before the queue head. Valid lanes are packed from lane 0 upward, and IDs increase with the lane number.
- R7: For each unit u, the number of lanes carrying unit u in a cycle is at most `unit_credit[u*CRED_W +: CRED_W]`. An entry skipped because its unit has no credit left does not block younger entries bound for other units.
- R8: At most `LANES` micro-ops are dispatched per cycle. The lane outputs follow R3 and R6 exactly.
- R9: While `flush` is 1, no lane is valid and no micro-op is accepted. From the next cycle the queue and window are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard queue and window contents |
| in_valid | input | 1 | Micro-op offered by rename |
| in_ready | output | 1 | Input queue has room |
| in_id | input | ID_W | Program-order ID |
| in_unit | input | UNIT_W | Target execution unit |
| in_dep_vld | input | 1 | Micro-op waits on a producer |
| in_dep_id | input | ID_W | Producer ID |
| in_data | input | DATA_W | Payload (address, opcode, operands) |
| wk_valid | input | 1 | Result broadcast valid |
| wk_id | input | ID_W | ID of the finished producer |
| unit_credit | input | 2**UNIT_W*CRED_W | Free issue-queue slots per unit |
| out_valid | output | LANES | Lane carries a micro-op |
| out_id | output | LANES*ID_W | Lane IDs |
| out_unit | output | LANES*UNIT_W | Lane unit selectors |
| out_data | output | LANES*DATA_W | Lane payloads |

## Verification
The ordering checks assume that program-order IDs are unique, that they grow with arrival, and that they do not wrap while any micro-op with that ID is still held. The age comparison is a plain unsigned compare. The stimulus therefore draws IDs from one counter that only advances on acceptance and stays far below the ID range. Wakeup IDs are picked from the dependencies actually pending in the reference model, so entries are not stranded. Producer IDs always name older micro-ops.

// File: rtl/dispatch_rs.sv
`timescale 1ns/1ps
module dispatch_rs #(
  parameter int UNIT_W = 1,
  parameter int WIN    = 8,
  parameter int QDEPTH = 4,
  parameter int LANES  = 2,
  parameter int ID_W   = 10,
  parameter int DATA_W = 16,
  parameter int CRED_W = 3
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [ID_W-1:0]               in_id,
  input  logic [UNIT_W-1:0]             in_unit,
  input  logic                          in_dep_vld,
  input  logic [ID_W-1:0]               in_dep_id,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          wk_valid,
  input  logic [ID_W-1:0]               wk_id,
  input  logic [(2**UNIT_W)*CRED_W-1:0] unit_credit,
  output logic [LANES-1:0]              out_valid,
  output logic [LANES*ID_W-1:0]         out_id,
  output logic [LANES*UNIT_W-1:0]       out_unit,
  output logic [LANES*DATA_W-1:0]       out_data
);
  localparam int UNITS = 2**UNIT_W;
  localparam int QW    = $clog2(QDEPTH);
  localparam int WW    = $clog2(WIN);
  localparam int NW    = $clog2(LANES+1);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [UNIT_W-1:0] unit;
    logic              dep;
    logic [ID_W-1:0]   dep_id;
    logic [DATA_W-1:0] data;
  } uop_t;

  uop_t            q_mem [QDEPTH];
  logic [QW-1:0]   q_rd, q_wr;
  logic [QW:0]     q_cnt;
  uop_t            w_mem [WIN];
  logic [WIN-1:0]  w_vld, taken;
  logic [CRED_W:0] used [UNITS];
  logic [NW-1:0]   nsel;
  logic [WW-1:0]   fslot;
  logic            byp, park, push, pop;
  uop_t            head;

  function automatic logic [CRED_W:0] room(input logic [UNIT_W-1:0] u);
    return {1'b0, unit_credit[u*CRED_W +: CRED_W]};
  endfunction

  function automatic logic woken(input logic [ID_W-1:0] d);
    return wk_valid && (d == wk_id);
  endfunction

  assign head     = q_mem[q_rd];
  assign in_ready = q_cnt < (QW+1)'(QDEPTH);
  assign push     = in_valid && in_ready && !flush;
  assign pop      = byp || park;

  always_comb begin
    logic          found;
    logic [WW-1:0] bi;
    taken     = '0;
    nsel      = '0;
    out_valid = '0;
    out_id    = '0;
    out_unit  = '0;
    out_data  = '0;
    for (int u = 0; u < UNITS; u++) used[u] = '0;
    for (int k = 0; k < LANES; k++) begin
      found = 1'b0;
      bi    = '0;
      for (int i = 0; i < WIN; i++)
        if (w_vld[i] && !w_mem[i].dep && !taken[i] &&
            used[w_mem[i].unit] < room(w_mem[i].unit) &&
            (!found || w_mem[i].id < w_mem[bi].id)) begin
          found = 1'b1;
          bi    = WW'(i);
        end
      if (found && !flush) begin
        taken[bi]                    = 1'b1;
        used[w_mem[bi].unit]         = used[w_mem[bi].unit] + (CRED_W+1)'(1);
        out_valid[k]                 = 1'b1;
        out_id[k*ID_W +: ID_W]       = w_mem[bi].id;
        out_unit[k*UNIT_W +: UNIT_W] = w_mem[bi].unit;
        out_data[k*DATA_W +: DATA_W] = w_mem[bi].data;
        nsel                         = nsel + NW'(1);
      end
    end
    byp = !flush && (q_cnt != '0) && !head.dep && (nsel < NW'(LANES)) &&
          (used[head.unit] < room(head.unit));
    for (int k = 0; k < LANES; k++)
      if (byp && NW'(k) == nsel) begin
        out_valid[k]                 = 1'b1;
        out_id[k*ID_W +: ID_W]       = head.id;
        out_unit[k*UNIT_W +: UNIT_W] = head.unit;
        out_data[k*DATA_W +: DATA_W] = head.data;
      end
    fslot = '0;
    for (int i = WIN-1; i >= 0; i--)
      if (!w_vld[i]) fslot = WW'(i);
    park = !flush && (q_cnt != '0) && !byp && !(&w_vld);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      q_rd  <= '0;
      q_wr  <= '0;
      q_cnt <= '0;
      w_vld <= '0;
    end else begin
      for (int i = 0; i < WIN; i++)
        if (w_vld[i] && w_mem[i].dep && woken(w_mem[i].dep_id)) w_mem[i].dep <= 1'b0;
      for (int i = 0; i < QDEPTH; i++)
        if (q_mem[i].dep && woken(q_mem[i].dep_id)) q_mem[i].dep <= 1'b0;
      w_vld <= (w_vld & ~taken) | (park ? (WIN'(1) << fslot) : '0);
      if (park) begin
        w_mem[fslot]     <= head;
        w_mem[fslot].dep <= head.dep && !woken(head.dep_id);
      end
      if (push) begin
        q_mem[q_wr] <= {in_id, in_unit, in_dep_vld && !woken(in_dep_id), in_dep_id, in_data};
        q_wr        <= q_wr + QW'(1);
      end
      if (pop) q_rd <= q_rd + QW'(1);
      q_cnt <= q_cnt + (QW+1)'(push) - (QW+1)'(pop);
    end
  end
endmodule

// File: rtl/dispatch_rs_chk.sv
`timescale 1ns/1ps
module dispatch_rs_chk #(
  parameter int UNIT_W = 1,
  parameter int WIN    = 8,
  parameter int QDEPTH = 4,
  parameter int LANES  = 2,
  parameter int ID_W   = 10,
  parameter int CRED_W = 3
)(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic                          in_ready,
  input logic [(2**UNIT_W)*CRED_W-1:0] unit_credit,
  input logic [LANES-1:0]              out_valid,
  input logic [LANES*ID_W-1:0]         out_id,
  input logic [LANES*UNIT_W-1:0]       out_unit,
  input logic [$clog2(QDEPTH):0]       q_cnt,
  input logic [WIN-1:0]                w_vld
);
  localparam int UNITS = 2**UNIT_W;
  localparam int CW    = $clog2(LANES+1);

  logic [CW-1:0] per_unit [UNITS];

  always_comb
    for (int u = 0; u < UNITS; u++) begin
      per_unit[u] = '0;
      for (int k = 0; k < LANES; k++)
        if (out_valid[k] && out_unit[k*UNIT_W +: UNIT_W] == UNIT_W'(u))
          per_unit[u] = per_unit[u] + CW'(1);
    end

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_cnt == '0 && w_vld == '0));

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> out_valid == '0);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt >= ($clog2(QDEPTH)+1)'(QDEPTH)) |-> !in_ready);

  genvar g;
  generate
    for (g = 0; g < UNITS; g++) begin : g_unit
      // R7
      credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(per_unit[g]) <= 32'(unit_credit[g*CRED_W +: CRED_W]));
    end
    for (g = 0; g + 1 < LANES; g++) begin : g_lane
      // R6
      lane_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[g+1] |-> out_valid[g]);
      // R6
      lane_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[g+1] |-> out_id[g*ID_W +: ID_W] < out_id[(g+1)*ID_W +: ID_W]);
    end
  endgenerate
endmodule

bind dispatch_rs dispatch_rs_chk #(
  .UNIT_W(UNIT_W), .WIN(WIN), .QDEPTH(QDEPTH), .LANES(LANES), .ID_W(ID_W), .CRED_W(CRED_W)
) u_chk (.*);

// File: tb/sim_dispatch_rs.sv
`timescale 1ns/1ps
module sim_dispatch_rs;
  localparam int UNIT_W = 1, UNITS = 2, WIN = 8, QDEPTH = 4, LANES = 2;
  localparam int ID_W = 10, DATA_W = 16, CRED_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_valid = 1'b0, in_ready, in_dep_vld = 1'b0, wk_valid = 1'b0;
  logic [ID_W-1:0] in_id = '0, in_dep_id = '0, wk_id = '0;
  logic [UNIT_W-1:0] in_unit = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [UNITS*CRED_W-1:0] unit_credit = '0;
  logic [LANES-1:0] out_valid;
  logic [LANES*ID_W-1:0] out_id;
  logic [LANES*UNIT_W-1:0] out_unit;
  logic [LANES*DATA_W-1:0] out_data;

  dispatch_rs #(.UNIT_W(UNIT_W), .WIN(WIN), .QDEPTH(QDEPTH), .LANES(LANES),
                .ID_W(ID_W), .DATA_W(DATA_W), .CRED_W(CRED_W)) u0 (.*);

  always #4 clk = ~clk;

  typedef struct {int id; int unit; bit dep; int dep_id; int data;} mop_t;
  mop_t mq[$], mw[$];
  int errors = 0, checks = 0, next_id = 0;
  string ptag = "";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0d exp=%0d", tag, ptag, what, act, exp);
    end
  endtask

  task automatic cycle(bit v, int pdep, bit fl, int pwk, int cmax);
    int c[UNITS], used[UNITS], ev[LANES], eid[LANES], eu[LANES], ed[LANES];
    int tk[$], pend[$];
    int n, wid;
    bit byp, park, acc, wv;
    mop_t nw, h;
    @(negedge clk);
    for (int u = 0; u < UNITS; u++) begin
      c[u] = $urandom_range(0, cmax);
      unit_credit[u*CRED_W +: CRED_W] = CRED_W'(c[u]);
      used[u] = 0;
    end
    nw.id = next_id;
    nw.unit = $urandom % UNITS;
    nw.dep = (next_id > 0) && ($urandom % 100 < pdep);
    nw.dep_id = (next_id > 0) ? next_id - 1 - $urandom % ((next_id < 3) ? next_id : 3) : 0;
    nw.data = $urandom % 65536;
    in_valid = v; in_id = ID_W'(nw.id); in_unit = UNIT_W'(nw.unit);
    in_dep_vld = nw.dep; in_dep_id = ID_W'(nw.dep_id); in_data = DATA_W'(nw.data);
    foreach (mw[i]) if (mw[i].dep) pend.push_back(mw[i].dep_id);
    foreach (mq[i]) if (mq[i].dep) pend.push_back(mq[i].dep_id);
    wv = ($urandom % 100) < pwk;
    wid = (pend.size() > 0) ? pend[$urandom % pend.size()] : 1000;
    wk_valid = wv; wk_id = ID_W'(wid);
    flush = fl;
    #1;
    n = 0;
    for (int k = 0; k < LANES; k++) begin ev[k] = 0; eid[k] = 0; eu[k] = 0; ed[k] = 0; end
    if (!fl)
      foreach (mw[i])
        if (!mw[i].dep && n < LANES && used[mw[i].unit] < c[mw[i].unit]) begin
          ev[n] = 1; eid[n] = mw[i].id; eu[n] = mw[i].unit; ed[n] = mw[i].data;
          used[mw[i].unit]++; n++; tk.push_back(i);
        end
    byp = !fl && mq.size() > 0 && !mq[0].dep && n < LANES && used[mq[0].unit] < c[mq[0].unit];
    if (byp) begin ev[n] = 1; eid[n] = mq[0].id; eu[n] = mq[0].unit; ed[n] = mq[0].data; end
    park = !fl && mq.size() > 0 && !byp && mw.size() < WIN;
    chk(in_ready == (mq.size() < QDEPTH), "R2", "in_ready", in_ready, mq.size() < QDEPTH);
    for (int k = 0; k < LANES; k++) begin
      chk(out_valid[k] == ev[k], fl ? "R9" : "R8", $sformatf("valid lane%0d", k), out_valid[k], ev[k]);
      if (ev[k] != 0) begin
        chk(int'(out_id[k*ID_W +: ID_W]) == eid[k], "R6", $sformatf("id lane%0d", k),
            out_id[k*ID_W +: ID_W], eid[k]);
        chk(int'(out_unit[k*UNIT_W +: UNIT_W]) == eu[k], "R3", $sformatf("unit lane%0d", k),
            out_unit[k*UNIT_W +: UNIT_W], eu[k]);
        chk(int'(out_data[k*DATA_W +: DATA_W]) == ed[k], "R3", $sformatf("data lane%0d", k),
            out_data[k*DATA_W +: DATA_W], ed[k]);
      end
    end
    acc = v && (mq.size() < QDEPTH) && !fl;
    @(posedge clk);
    if (fl) begin
      mq.delete(); mw.delete();
    end else begin
      if (wv) begin
        foreach (mw[i]) if (mw[i].dep && mw[i].dep_id == wid) mw[i].dep = 0;
        foreach (mq[i]) if (mq[i].dep && mq[i].dep_id == wid) mq[i].dep = 0;
      end
      for (int j = tk.size() - 1; j >= 0; j--) mw.delete(tk[j]);
      if (byp || park) begin
        h = mq.pop_front();
        if (park) mw.push_back(h);
      end
      if (acc) begin
        if (wv && nw.dep && nw.dep_id == wid) nw.dep = 0;
        mq.push_back(nw);
      end
    end
    if (acc) next_id++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    ptag = "reset";
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    ptag = "R3 free flow";
    repeat (40) cycle(1, 0, 0, 0, 3);
    ptag = "R4 window fill";
    repeat (16) cycle(1, 0, 0, 0, 0);
    repeat (20) cycle(1, 0, 0, 0, 1);
    ptag = "R5 wakeups";
    repeat (60) cycle(1, 60, 0, 40, 3);
    ptag = "R7 tight credit";
    repeat (40) cycle(1, 30, 0, 50, 1);
    ptag = "R9 flushes";
    for (int i = 0; i < 40; i++) cycle(1, 40, (i % 7) == 6, 40, 2);
    ptag = "R2 stall and drain";
    repeat (20) cycle(1, 20, 0, 30, 0);
    repeat (40) cycle(0, 0, 0, 80, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule